// File: doc/BRIEF.md
# Sample Fetch Address Generator

This block produces the byte addresses a sample-playback DMA engine reads from. It holds a 15-bit current address and drives it onto a 16-bit bus address. The top bus bit is always 1, so every fetch falls in the upper half of the address space. A start request loads the address from an 8-bit base value. Bit 14 is forced high, the base value fills bits 13 down to 6, and the low six bits are cleared. The first fetch of a sample is therefore at 0xC000 + base × 64.

A remaining-byte counter is loaded from an 8-bit length value as length × 16 + 1. Each fetch acknowledge moves the address forward by one byte and takes one off the counter. Because the register has only 15 bits, stepping past 0xFFFF lands on 0x8000. When the last byte is acknowledged, one of two things happens. With the repeat flag set, the sample restarts at once. Without it, a one-cycle end-of-sample pulse is raised and the block waits for the next start. Deciding who owns the bus is left to the surrounding engine.

Top module: `sfa_addr_gen`

## Requirements
- R1: Bit 15 of `addr_o` is 1 in every cycle after reset. Only bits 14..0 are held in state.
- R2: An accepted start sets `addr_o[14]` to 1 and `addr_o[13:6]` to `base_i`, whatever the base value is, on the next clock edge.
- R3: An accepted start clears `addr_o[5:0]` to 0.
- R4: An accepted acknowledge does two things, both visible after the next edge: `addr_o[14:0]` goes up by exactly 1, and `remaining_o` goes down by exactly 1. One exception: the last byte under R10.
- R5: An accepted acknowledge at `addr_o` = 0xFFFF gives `addr_o` = 0x8000.
- R6: An accepted start loads `remaining_o` with `len_i` × 16 + 1. The range is 1 to 4081.
- R7: `start_i` is accepted only while `remaining_o` is 0. While it is non-zero, `start_i` changes neither the address nor the count.
- R8: `ack_i` is ignored while `remaining_o` is 0. If `start_i` is high in the same cycle, the load is done and the acknowledge is dropped.
- R9: An acknowledge at `remaining_o` = 1 with `loop_i` = 0 has three effects. It steps the address as in R4. It leaves `remaining_o` at 0. It raises `done_o` for exactly one cycle, after that same edge.
- R10: An acknowledge at `remaining_o` = 1 with `loop_i` = 1 reloads the address as in R2/R3 and the count as in R6 on that edge, and `done_o` stays 0.
- R11: After a synchronous reset, `addr_o` is 0xC000, `remaining_o` is 0 and `done_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_i | input | 8 | Programmed sample start value (address bits 13..6) |
| len_i | input | 8 | Programmed sample length value (bytes = len × 16 + 1) |
| loop_i | input | 1 | Restart the sample automatically after its last byte |
| start_i | input | 1 | Request to load address and count (taken only when idle) |
| ack_i | input | 1 | One byte has been fetched at the current address |
| addr_o | output | 16 | Bus address of the next byte to fetch |
| remaining_o | output | 12 | Bytes still to fetch in the current sample |
| done_o | output | 1 | One-cycle pulse after the last byte of a non-repeating sample |

## Verification
The bench builds the block with its default widths: a 15-bit address register, 8-bit base and length fields, and a ×16 length scale. With these widths, a base of 0xFF places the first byte 64 bytes below the top of memory, so the wrap from 0xFFFF to 0x8000 is reached after 64 acknowledges. A length of 0 gives a one-byte sample, which puts a start, the last byte and the end pulse within three cycles. A length of 0xFF shows that the 12-bit counter holds its largest load of 4081. The repeat case uses a 17-byte sample, so the automatic reload is seen in the same cycle as the final step would have happened.

// File: rtl/sfa_pkg.sv
package sfa_pkg;

    // Default geometry of the fetch address generator
    localparam int SFA_ADDR_W    = 15;  // bits held in the address register
    localparam int SFA_BASE_W    = 8;   // width of the programmed start value
    localparam int SFA_LEN_W     = 8;   // width of the programmed length value
    localparam int SFA_LEN_SHIFT = 4;   // length scale: bytes = len << shift, plus one

    // Action applied to address and counter on the coming edge
    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_LOAD = 2'd1,
        ACT_STEP = 2'd2
    } sfa_act_e;

    // Decision bundle from the control unit
    typedef struct packed {
        sfa_act_e act;
        logic     finish;   // last byte of a non-repeating sample
    } sfa_cmd_t;

endpackage

// File: rtl/sfa_ctrl.sv
module sfa_ctrl
    import sfa_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     start_i,
    input  logic     ack_i,
    input  logic     loop_i,
    input  logic     cnt_zero_i,
    input  logic     cnt_one_i,
    output sfa_cmd_t cmd_o,
    output logic     done_o
);

    sfa_cmd_t cmd;
    logic     done_q;

    // Idle: only a start matters. Busy: only an acknowledge matters.
    always_comb begin
        cmd.act    = ACT_HOLD;
        cmd.finish = 1'b0;
        if (cnt_zero_i) begin
            if (start_i) begin
                cmd.act = ACT_LOAD;
            end
        end else if (ack_i) begin
            if (cnt_one_i && loop_i) begin
                cmd.act = ACT_LOAD;
            end else begin
                cmd.act    = ACT_STEP;
                cmd.finish = cnt_one_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q <= 1'b0;
        end else begin
            done_q <= cmd.finish;
        end
    end

    assign cmd_o  = cmd;
    assign done_o = done_q;

endmodule

// File: rtl/sfa_addr_reg.sv
module sfa_addr_reg
    import sfa_pkg::*;
#(
    parameter int ADDR_W = SFA_ADDR_W,
    parameter int BASE_W = SFA_BASE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  sfa_act_e          act_i,
    input  logic [BASE_W-1:0] base_i,
    output logic [ADDR_W-1:0] addr_o
);

    localparam int LOW_W = ADDR_W - 1 - BASE_W;  // cleared bits below the base field

    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] start_addr;

    assign start_addr = {1'b1, base_i, {LOW_W{1'b0}}};

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= {1'b1, {(ADDR_W-1){1'b0}}};
        end else begin
            unique case (act_i)
                ACT_LOAD: addr_q <= start_addr;
                ACT_STEP: addr_q <= addr_q + 1'b1;   // natural 15-bit wrap
                default:  addr_q <= addr_q;
            endcase
        end
    end

    assign addr_o = addr_q;

    // R3: a load always leaves the low field clear
    assert_load_low_clear_R3: assert property (@(posedge clk) disable iff (rst)
        (act_i == ACT_LOAD) |=> (addr_q[LOW_W-1:0] == '0));

endmodule

// File: rtl/sfa_byte_cnt.sv
module sfa_byte_cnt
    import sfa_pkg::*;
#(
    parameter int LEN_W     = SFA_LEN_W,
    parameter int LEN_SHIFT = SFA_LEN_SHIFT
) (
    input  logic                        clk,
    input  logic                        rst,
    input  sfa_act_e                    act_i,
    input  logic [LEN_W-1:0]            len_i,
    output logic [LEN_W+LEN_SHIFT-1:0]  count_o,
    output logic                        zero_o,
    output logic                        one_o
);

    localparam int CNT_W = LEN_W + LEN_SHIFT;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] load_val;

    assign load_val = {len_i, {LEN_SHIFT{1'b0}}} + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            unique case (act_i)
                ACT_LOAD: cnt_q <= load_val;
                ACT_STEP: cnt_q <= cnt_q - 1'b1;
                default:  cnt_q <= cnt_q;
            endcase
        end
    end

    assign count_o = cnt_q;
    assign zero_o  = (cnt_q == '0);
    assign one_o   = (cnt_q == {{(CNT_W-1){1'b0}}, 1'b1});

    // R8: the counter is never stepped below zero
    assert_no_underflow_R8: assert property (@(posedge clk) disable iff (rst)
        zero_o |-> (act_i != ACT_STEP));

endmodule

// File: rtl/sfa_addr_gen.sv
module sfa_addr_gen
    import sfa_pkg::*;
#(
    parameter int ADDR_W    = SFA_ADDR_W,
    parameter int BASE_W    = SFA_BASE_W,
    parameter int LEN_W     = SFA_LEN_W,
    parameter int LEN_SHIFT = SFA_LEN_SHIFT
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [BASE_W-1:0]          base_i,
    input  logic [LEN_W-1:0]           len_i,
    input  logic                       loop_i,
    input  logic                       start_i,
    input  logic                       ack_i,
    output logic [ADDR_W:0]            addr_o,
    output logic [LEN_W+LEN_SHIFT-1:0] remaining_o,
    output logic                       done_o
);

    localparam int CNT_W = LEN_W + LEN_SHIFT;

    sfa_cmd_t          cmd;
    logic              cnt_zero;
    logic              cnt_one;
    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  cnt;

    sfa_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .ack_i      (ack_i),
        .loop_i     (loop_i),
        .cnt_zero_i (cnt_zero),
        .cnt_one_i  (cnt_one),
        .cmd_o      (cmd),
        .done_o     (done_o)
    );

    sfa_addr_reg #(
        .ADDR_W (ADDR_W),
        .BASE_W (BASE_W)
    ) u_addr (
        .clk    (clk),
        .rst    (rst),
        .act_i  (cmd.act),
        .base_i (base_i),
        .addr_o (addr_q)
    );

    sfa_byte_cnt #(
        .LEN_W     (LEN_W),
        .LEN_SHIFT (LEN_SHIFT)
    ) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .act_i   (cmd.act),
        .len_i   (len_i),
        .count_o (cnt),
        .zero_o  (cnt_zero),
        .one_o   (cnt_one)
    );

    assign addr_o      = {1'b1, addr_q};
    assign remaining_o = cnt;

    // Port-level checks relating inputs to the state seen after the edge

    // R2: accepted start forces bit 14 and places the base value
    assert_load_base_R2: assert property (@(posedge clk) disable iff (rst)
        (start_i && remaining_o == '0) |=>
            (addr_o[ADDR_W-1] && addr_o[ADDR_W-2 -: BASE_W] == $past(base_i)));

    // R4: an ordinary accepted acknowledge moves both by one
    assert_step_one_R4: assert property (@(posedge clk) disable iff (rst)
        (ack_i && remaining_o > CNT_W'(1)) |=>
            (addr_o[ADDR_W-1:0] == ADDR_W'($past(addr_o[ADDR_W-1:0]) + 1'b1)
             && remaining_o == CNT_W'($past(remaining_o) - 1'b1)));

    // R5: stepping off the top of memory lands at the bottom of the upper half
    assert_wrap_R5: assert property (@(posedge clk) disable iff (rst)
        (ack_i && remaining_o > CNT_W'(1) && (&addr_o)) |=>
            (addr_o == {1'b1, {ADDR_W{1'b0}}}));

    // R7: start while busy leaves the count alone unless an ack is taken
    assert_busy_start_ignored_R7: assert property (@(posedge clk) disable iff (rst)
        (start_i && !ack_i && remaining_o != '0) |=>
            ($stable(addr_o) && $stable(remaining_o)));

    // R9: the end pulse lasts a single cycle and comes with an empty counter
    assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (remaining_o == '0) ##1 !done_o);

    // R1: the fixed top bit
    assert_top_bit_R1: assert property (@(posedge clk) disable iff (rst)
        addr_o[ADDR_W]);

endmodule

// File: tb/sfa_addr_gen_tb.sv
module sfa_addr_gen_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  base_i;
    logic [7:0]  len_i;
    logic        loop_i;
    logic        start_i;
    logic        ack_i;
    logic [15:0] addr_o;
    logic [11:0] remaining_o;
    logic        done_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;   // 50 MHz

    sfa_addr_gen u_dut (
        .clk         (clk),
        .rst         (rst),
        .base_i      (base_i),
        .len_i       (len_i),
        .loop_i      (loop_i),
        .start_i     (start_i),
        .ack_i       (ack_i),
        .addr_o      (addr_o),
        .remaining_o (remaining_o),
        .done_o      (done_o)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Called at a falling edge; applies one cycle of strobes and returns at the next falling edge
    task automatic cyc(input logic s, input logic a);
        start_i = s;
        ack_i   = a;
        @(negedge clk);
        start_i = 1'b0;
        ack_i   = 1'b0;
    endtask

    task automatic acks(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b1);
    endtask

    task automatic t_reset;
        rst = 1'b1; start_i = 0; ack_i = 0; loop_i = 0; base_i = 8'h00; len_i = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R11", "reset addr", 32'(addr_o), 32'hC000);
        chk("R11", "reset count", 32'(remaining_o), 32'd0);
        chk("R11", "reset done", 32'(done_o), 32'd0);
    endtask

    task automatic t_one_byte;
        base_i = 8'h00; len_i = 8'h00; loop_i = 1'b0;
        cyc(1'b1, 1'b0);
        chk("R2", "start addr base 00", 32'(addr_o), 32'hC000);
        chk("R6", "count len 0", 32'(remaining_o), 32'd1);
        chk("R9", "no done before last", 32'(done_o), 32'd0);
        cyc(1'b0, 1'b1);
        chk("R4", "addr after last ack", 32'(addr_o), 32'hC001);
        chk("R9", "count empty", 32'(remaining_o), 32'd0);
        chk("R9", "done pulse", 32'(done_o), 32'd1);
        @(negedge clk);
        chk("R9", "done falls", 32'(done_o), 32'd0);
        chk("R9", "addr held after end", 32'(addr_o), 32'hC001);
    endtask

    task automatic t_idle_ack;
        cyc(1'b0, 1'b1);
        chk("R8", "idle ack addr", 32'(addr_o), 32'hC001);
        chk("R8", "idle ack count", 32'(remaining_o), 32'd0);
        chk("R8", "idle ack no done", 32'(done_o), 32'd0);
    endtask

    task automatic t_mid_base;
        base_i = 8'hA5; len_i = 8'h02; loop_i = 1'b0;
        cyc(1'b1, 1'b0);
        chk("R2", "start addr base A5", 32'(addr_o), 32'hE940);
        chk("R3", "low bits clear", 32'(addr_o[5:0]), 32'd0);
        chk("R6", "count len 2", 32'(remaining_o), 32'd33);
        cyc(1'b0, 1'b1);
        chk("R4", "step addr", 32'(addr_o), 32'hE941);
        chk("R4", "step count", 32'(remaining_o), 32'd32);
        base_i = 8'h00;
        cyc(1'b1, 1'b0);
        chk("R7", "busy start addr", 32'(addr_o), 32'hE941);
        chk("R7", "busy start count", 32'(remaining_o), 32'd32);
        acks(31);
        chk("R4", "addr before last", 32'(addr_o), 32'hE960);
        chk("R9", "no early done", 32'(done_o), 32'd0);
        cyc(1'b0, 1'b1);
        chk("R9", "done after 33 bytes", 32'(done_o), 32'd1);
        chk("R4", "final addr", 32'(addr_o), 32'hE961);
        @(negedge clk);
    endtask

    task automatic t_wrap;
        base_i = 8'hFF; len_i = 8'h04; loop_i = 1'b0;
        cyc(1'b1, 1'b0);
        chk("R2", "start addr base FF", 32'(addr_o), 32'hFFC0);
        chk("R6", "count len 4", 32'(remaining_o), 32'd65);
        acks(63);
        chk("R4", "top of memory", 32'(addr_o), 32'hFFFF);
        chk("R4", "count at top", 32'(remaining_o), 32'd2);
        cyc(1'b0, 1'b1);
        chk("R5", "wrap target", 32'(addr_o), 32'h8000);
        chk("R1", "top bit after wrap", 32'(addr_o[15]), 32'd1);
        cyc(1'b0, 1'b1);
        chk("R4", "after wrap step", 32'(addr_o), 32'h8001);
        chk("R9", "wrap sample done", 32'(done_o), 32'd1);
        @(negedge clk);
    endtask

    task automatic t_loop;
        base_i = 8'h10; len_i = 8'h01; loop_i = 1'b1;
        cyc(1'b1, 1'b0);
        chk("R2", "loop start addr", 32'(addr_o), 32'hC400);
        chk("R6", "loop count", 32'(remaining_o), 32'd17);
        acks(16);
        chk("R4", "loop before last", 32'(addr_o), 32'hC410);
        cyc(1'b0, 1'b1);
        chk("R10", "loop reload addr", 32'(addr_o), 32'hC400);
        chk("R10", "loop reload count", 32'(remaining_o), 32'd17);
        chk("R10", "loop no done", 32'(done_o), 32'd0);
        loop_i = 1'b0;
        acks(17);
        chk("R9", "end after loop off", 32'(done_o), 32'd1);
        chk("R4", "addr after loop off", 32'(addr_o), 32'hC411);
        @(negedge clk);
    endtask

    task automatic t_max_len;
        base_i = 8'h3C; len_i = 8'hFF; loop_i = 1'b0;
        cyc(1'b1, 1'b1);   // start and ack together while idle: load wins
        chk("R8", "start with ack addr", 32'(addr_o), 32'hCF00);
        chk("R6", "max count", 32'(remaining_o), 32'd4081);
    endtask

    initial begin
        t_reset();
        t_one_byte();
        t_idle_ack();
        t_mid_base();
        t_wrap();
        t_loop();
        t_max_len();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule